// File: doc/BRIEF.md
# Glitch-free Reprogrammable Clock Divider

This block is the output stage of a low-frequency timer. It runs on a master clock and produces one divided clock. The division ratio comes from a small divide code. A code value N selects a half-period of 2^N master cycles.

After power-on reset, the output is held low for a fixed start-up window. While this window lasts, the divide code is not trusted. When the window ends, the block captures the output polarity and the code present on that edge, then starts dividing. The polarity can be normal or inverted.

Later code changes pass through a settling filter before they take effect. A settled code applies to the phase already in progress. The output is a single register, so every high and low phase lasts at least one master period and has no glitch. A pulse-suppress input parks the output at its inactive level and restarts the phase counter.

Top module: `glitchless_divider`

## Requirements
- R1: While `porRst` is high, `divOut` is 0.
- R2: After `porRst` falls, `divOut` stays 0 through the first 499 rising edges. On the 500th edge (the start edge) the divider starts, and `divOut` takes the inactive level, which equals `polSel` sampled on that edge.
- R3: While running with `pulseRst` low, a 4-bit unsigned `divCode` value N makes every high and low phase exactly 2^N master cycles long. N = 0 toggles `divOut` on every edge. With normal polarity, the first transition comes 2^N edges after the start edge.
- R4: If `polSel` was 1 on the start edge and `pulseRst` is low on the next edge, `divOut` falls on that next edge. If `pulseRst` is high on that edge instead, `divOut` stays high.
- R5: While running, every edge that samples `pulseRst` high leaves `divOut` at the inactive level and clears the phase count. Once `pulseRst` is low again, the first transition lands on the 2^N-th edge that samples it low.
- R6: After the start edge, `polSel` has no effect on `divOut`. This includes the level held while `pulseRst` is high.
- R7: A new code value is adopted only when it was sampled on the edge where it first appeared and on 16 further consecutive edges. It is adopted on the 16th of those further edges. A value that changes sooner is never adopted.
- R8: An adopted code governs the phase in progress. If that phase has already lasted 2^N cycles or more at the adoption edge, it ends on the next edge. Otherwise it ends when it reaches 2^N cycles. No phase is shorter than one master cycle.
- R9: Code changes during the start-up window are ignored. The code present on the start edge applies at once, without settling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| porRst | input | 1 | Power-on reset, active high, asynchronous |
| divCode | input | 4 | Divide code N, half-period 2^N master cycles |
| polSel | input | 1 | Output polarity, 1 = inverted, captured on the start edge |
| pulseRst | input | 1 | Pulse suppress, active high |
| divOut | output | 1 | Divided clock |

## Verification
The assertions watch these properties on every cycle:
- the output stays low before the start edge;
- the output shows the inactive level after the start edge and after every suppressed edge;
- in inverted mode, the first fall comes one cycle after start;
- the active code changes only on a settle strobe from the control side, or on the start edge.

Exact phase lengths need the bench's behavioural model and directed scenarios. These include reprogramming partway through a phase, short code excursions that must be rejected, codes that change during start-up, and polarity changes after start.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic startEnd;    // the start edge is happening now
    logic run;         // divider has started
    logic hold;        // suppress pulses this edge
    logic codeLoad;    // settled code ready to adopt
    logic invertNext;  // polarity in force after this edge
  } gdiv_strobe_t;

endpackage

// File: rtl/gdiv_ctrl.sv
module gdiv_ctrl
  import gdiv_pkg::*;
#(
  parameter int CODE_W        = 4,
  parameter int START_CYCLES  = 500,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              rstIn,
  input  logic              polIn,
  input  logic [CODE_W-1:0] codeIn,
  output gdiv_strobe_t      strobes,
  output logic [CODE_W-1:0] codeVal
);

  localparam int START_W     = $clog2(START_CYCLES);
  localparam int SETTLE_W    = $clog2(SETTLE_CYCLES);
  localparam int START_LAST  = START_CYCLES - 1;
  localparam int SETTLE_LAST = SETTLE_CYCLES - 1;

  logic [START_W-1:0]  startCnt;
  logic                running;
  logic                polReg;
  logic [CODE_W-1:0]   candCode;
  logic [SETTLE_W-1:0] stabCnt;

  logic startEnd;
  logic settled;

  assign startEnd = !running && (startCnt == START_W'(START_LAST));
  assign settled  = running && (codeIn == candCode) &&
                    (stabCnt == SETTLE_W'(SETTLE_LAST));

  always_comb begin
    strobes.startEnd   = startEnd;
    strobes.run        = running;
    strobes.hold       = running && rstIn;
    strobes.codeLoad   = settled;
    strobes.invertNext = startEnd ? polIn : polReg;
    codeVal            = startEnd ? codeIn : candCode;
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      startCnt <= '0;
      running  <= 1'b0;
      polReg   <= 1'b0;
      candCode <= '0;
      stabCnt  <= '0;
    end else if (!running) begin
      // start-up window: filter tracks the input without counting
      candCode <= codeIn;
      stabCnt  <= '0;
      if (startEnd) begin
        running <= 1'b1;
        polReg  <= polIn;
      end else begin
        startCnt <= startCnt + START_W'(1);
      end
    end else begin
      if (codeIn != candCode) begin
        candCode <= codeIn;
        stabCnt  <= '0;
      end else if (stabCnt != SETTLE_W'(SETTLE_LAST)) begin
        stabCnt <= stabCnt + SETTLE_W'(1);
      end
    end
  end

endmodule

// File: rtl/gdiv_datapath.sv
module gdiv_datapath
  import gdiv_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              porRst,
  input  gdiv_strobe_t      strobes,
  input  logic [CODE_W-1:0] codeVal,
  output logic              divOut,
  output logic [CODE_W-1:0] activeCode
);

  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] phaseCnt;
  logic             level;

  logic [CNT_W-1:0]  nextCnt;
  logic              nextLevel;
  logic [CODE_W-1:0] nextCode;
  logic              nextOut;
  logic [CNT_W-1:0]  term;

  // last count value of a phase: 2^N - 1 (wraps cleanly at the top code)
  function automatic logic [CNT_W-1:0] termOf(input logic [CODE_W-1:0] c);
    return (CNT_W'(1) << c) - CNT_W'(1);
  endfunction

  assign term = termOf(activeCode);

  always_comb begin
    nextLevel = 1'b0;
    nextCnt   = '0;
    if (strobes.startEnd) begin
      // inverted start: preload so the first active phase begins next edge
      nextCnt = strobes.invertNext ? '1 : '0;
    end else if (strobes.run && !strobes.hold) begin
      if (phaseCnt >= term) begin
        nextLevel = !level;
      end else begin
        nextLevel = level;
        nextCnt   = phaseCnt + CNT_W'(1);
      end
    end
    nextCode = (strobes.startEnd || strobes.codeLoad) ? codeVal : activeCode;
    nextOut  = (strobes.startEnd || strobes.run) ?
               (nextLevel ^ strobes.invertNext) : 1'b0;
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      phaseCnt   <= '0;
      level      <= 1'b0;
      activeCode <= '0;
      divOut     <= 1'b0;
    end else begin
      phaseCnt   <= nextCnt;
      level      <= nextLevel;
      activeCode <= nextCode;
      divOut     <= nextOut;
    end
  end

endmodule

// File: rtl/glitchless_divider.sv
module glitchless_divider
  import gdiv_pkg::*;
#(
  parameter int CODE_W        = 4,
  parameter int START_CYCLES  = 500,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic [CODE_W-1:0] divCode,
  input  logic              polSel,
  input  logic              pulseRst,
  output logic              divOut
);

  gdiv_strobe_t      strobes;
  logic [CODE_W-1:0] codeVal;
  logic [CODE_W-1:0] activeCode;

  gdiv_ctrl #(
    .CODE_W       (CODE_W),
    .START_CYCLES (START_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .porRst (porRst),
    .rstIn  (pulseRst),
    .polIn  (polSel),
    .codeIn (divCode),
    .strobes(strobes),
    .codeVal(codeVal)
  );

  gdiv_datapath #(
    .CODE_W(CODE_W)
  ) u_dp (
    .clk       (clk),
    .porRst    (porRst),
    .strobes   (strobes),
    .codeVal   (codeVal),
    .divOut    (divOut),
    .activeCode(activeCode)
  );

endmodule

// File: rtl/gdiv_checker.sv
module gdiv_checker
  import gdiv_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              porRst,
  input logic              rstIn,
  input logic              polIn,
  input logic [CODE_W-1:0] divCode,
  input logic              divOut,
  input gdiv_strobe_t      strobes,
  input logic [CODE_W-1:0] activeCode
);

  // R1
  off_before_start_chk: assert property (@(posedge clk) disable iff (porRst)
    !strobes.run |-> (divOut == 1'b0));

  // R2
  start_level_chk: assert property (@(posedge clk) disable iff (porRst)
    strobes.startEnd |=> (divOut == $past(polIn)));

  // R4
  inv_first_fall_chk: assert property (@(posedge clk) disable iff (porRst)
    ($rose(strobes.run) && divOut && !rstIn) |=> !divOut);

  // R5
  hold_level_chk: assert property (@(posedge clk) disable iff (porRst)
    strobes.hold |=> (divOut == strobes.invertNext));

  // R7
  code_settle_chk: assert property (@(posedge clk) disable iff (porRst)
    (strobes.run && $past(strobes.run) && (activeCode != $past(activeCode)))
      |-> $past(strobes.codeLoad));

  // R9
  start_code_chk: assert property (@(posedge clk) disable iff (porRst)
    strobes.startEnd |=> (activeCode == $past(divCode)));

endmodule

bind glitchless_divider gdiv_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .porRst    (porRst),
  .rstIn     (pulseRst),
  .polIn     (polSel),
  .divCode   (divCode),
  .divOut    (divOut),
  .strobes   (strobes),
  .activeCode(activeCode)
);

// File: tb/glitchless_divider_tb.sv
`timescale 1ns/1ps
module glitchless_divider_tb;

  logic       clk = 1'b0;
  logic       porRst = 1'b1;
  logic [3:0] divCode = 4'd2;
  logic       polSel = 1'b0;
  logic       pulseRst = 1'b0;
  logic       divOut;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  always #2.5 clk = ~clk;

  glitchless_divider u_dut (
    .clk     (clk),
    .porRst  (porRst),
    .divCode (divCode),
    .polSel  (polSel),
    .pulseRst(pulseRst),
    .divOut  (divOut)
  );

  // Behavioural reference model, built from the requirements
  int mStartSeen, mCand, mStab, mActive, mPhase, mActiveHalf;
  bit mRun, mPol, mLevel, mOut;

  always @(posedge clk or posedge porRst) begin
    if (porRst) begin
      mRun = 0; mStartSeen = 0; mPol = 0; mLevel = 0; mOut = 0;
      mCand = 0; mStab = 0; mActive = 0; mPhase = 0;
    end else if (!mRun) begin
      mStartSeen++;
      mCand = divCode; mStab = 0;
      if (mStartSeen == 500) begin
        mRun = 1; mPol = polSel; mActive = divCode; mLevel = 0;
        mPhase = mPol ? 1 << 20 : 0;   // inverted: first phase ends at once
      end
    end else begin
      bit adopt;
      adopt = (divCode == mCand) && (mStab == 15);
      mActiveHalf = 1 << mActive;
      if (pulseRst) begin
        mLevel = 0; mPhase = 0;
      end else if (mPhase + 1 >= mActiveHalf) begin
        mLevel = !mLevel; mPhase = 0;
      end else begin
        mPhase++;
      end
      if (adopt) mActive = mCand;
      if (divCode != mCand) begin
        mCand = divCode; mStab = 0;
      end else if (mStab < 15) begin
        mStab++;
      end
    end
    mOut = mRun ? (mLevel ^ mPol) : 1'b0;
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (divOut !== mOut) begin
        errors++;
        $display("FAIL %s cycle compare: divOut=%0b expected %0b at %0t",
                 curTag, divOut, mOut, $time);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitChange(input int lim, output int n);
    logic s;
    s = divOut;
    n = 0;
    while (divOut == s && n < lim) begin
      step();
      n++;
    end
  endtask

  // releases porRst and runs to just after the start edge
  task automatic startUp(input int changeAt, input logic [3:0] lateCode);
    int bad;
    bad = 0;
    porRst = 1'b0;
    for (int i = 0; i < 499; i++) begin
      step();
      if (divOut) bad++;
      if (i == changeAt) divCode = lateCode;
    end
    check("R2 low through start-up", bad, 0);
    step();
  endtask

  initial begin
    int n;
    // ---- normal polarity, code 2
    curTag = "R1";
    repeat (3) step();
    check("R1 low in reset", divOut, 0);
    curTag = "R2";
    startUp(-1, 4'd2);
    check("R2 start level normal", divOut, 0);
    curTag = "R3";
    waitChange(100, n);
    check("R3 first phase code2", n, 4);
    waitChange(100, n);
    check("R3 phase code2", n, 4);
    divCode = 4'd0;
    repeat (20) step();
    waitChange(100, n);
    waitChange(100, n);
    check("R3 phase code0", n, 1);
    divCode = 4'd2;
    repeat (20) step();

    // ---- polarity ignored after start, pulse suppression
    curTag = "R6";
    polSel = 1'b1;
    repeat (3) step();
    waitChange(100, n);
    waitChange(100, n);
    check("R6 phase unchanged by polSel", n, 4);
    pulseRst = 1'b1;
    step(); step();
    check("R6 hold level ignores polSel", divOut, 0);
    curTag = "R5";
    repeat (8) step();
    check("R5 held inactive", divOut, 0);
    pulseRst = 1'b0;
    waitChange(100, n);
    check("R5 first phase after release", n, 4);
    polSel = 1'b0;

    // ---- settling filter
    curTag = "R7";
    waitChange(100, n);
    divCode = 4'd5;
    repeat (10) step();
    divCode = 4'd2;
    repeat (30) step();
    waitChange(100, n);
    waitChange(100, n);
    check("R7 short excursion rejected", n, 4);
    divCode = 4'd3;
    repeat (40) step();
    waitChange(100, n);
    waitChange(100, n);
    check("R7 settled code adopted", n, 8);

    // ---- reprogramming mid-phase
    curTag = "R8";
    divCode = 4'd5;
    repeat (60) step();
    waitChange(200, n);
    repeat (5) step();
    divCode = 4'd1;
    waitChange(200, n);
    check("R8 phase cut after adoption", n, 18);
    waitChange(200, n);
    check("R8 new ratio", n, 2);

    // ---- inverted start, reset low
    curTag = "R4";
    porRst = 1'b1; polSel = 1'b1; divCode = 4'd0; pulseRst = 1'b0;
    repeat (3) step();
    check("R1 low in reset inverted", divOut, 0);
    startUp(-1, 4'd0);
    check("R4 inactive high at start", divOut, 1);
    step();
    check("R4 falls one period later", divOut, 0);
    waitChange(100, n);
    check("R3 inverted code0 phase", n, 1);

    // ---- inverted start, reset held
    porRst = 1'b1; pulseRst = 1'b1;
    repeat (3) step();
    startUp(-1, 4'd0);
    check("R4 held high at start", divOut, 1);
    repeat (6) step();
    check("R4 stays high under reset", divOut, 1);
    curTag = "R5";
    pulseRst = 1'b0;
    waitChange(100, n);
    check("R5 release inverted", n, 1);

    // ---- code change during start-up
    curTag = "R9";
    porRst = 1'b1; polSel = 1'b0; divCode = 4'd6;
    repeat (3) step();
    startUp(494, 4'd1);
    waitChange(200, n);
    check("R9 start code applied at once", n, 2);
    waitChange(200, n);
    check("R9 start code phase", n, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule